// File: doc/BRIEF.md
# Ordering-Policy Store Buffer

This block sits between a processor's memory port and a write-through lower level: a first-level cache or the next memory stage. Stores from the processor are parked in a small slot buffer and retired to the lower level one per handshake. Loads never read from that buffer. Every load goes to the lower level, and the processor waits for its data.

A two-bit runtime mode sets which program-order pairs may be relaxed. In sequential mode nothing is relaxed, so a load waits until every buffered store has retired. In total-store-order mode a load may overtake pending stores, but stores still retire in the order they arrived. In partial-store-order mode stores to different addresses may also retire out of order, while stores to one address keep their order.

Only one load is open at a time, and no request is taken while it is open. This keeps load→load and load→store order in every mode. A fence request is accepted only once the block is completely quiet.

Top module: `store_order_buf`

## Requirements
- R1: A load is never answered from buffered store data. A load to an address that has a pending store returns the value the lower level delivers on mem_rsp_rdata_i.
- R2: mode_i is encoded as follows: 0 and 3 select sequential mode, 1 selects total-store-order, 2 selects partial-store-order. In sequential mode req_ready_o stays low for a load request while any store is buffered.
- R3: In total-store-order and partial-store-order modes a load is accepted while stores are pending. Once accepted, it holds the lower port (mem_req_valid_o=1, mem_req_write_o=0) ahead of every buffered store.
- R4: In sequential and total-store-order modes, stores reach the lower level in exactly the order they were accepted.
- R5: In partial-store-order mode a store takes the lowest-numbered free slot. The store offered next is the one in the lowest-numbered slot whose address has no older pending store. Stores to the same address therefore retire in program order.
- R6: With DEPTH stores pending, req_ready_o is low for a store request.
- R7: From the cycle a load is accepted until its response is taken, req_ready_o is low for every request.
- R8: A request with req_fence_i=1 is a fence, whatever req_write_i says. It is accepted only when no store is pending and no load is open, and it produces no lower-level request.
- R9: rsp_valid_o stays high, with rsp_rdata_o unchanged, until rsp_ready_i is seen high.
- R10: After reset, req_ready_o=1, mem_req_valid_o=0 and rsp_valid_o=0.
- R11: A store retires in the cycle mem_req_valid_o, mem_req_ready_i and mem_req_write_o are all high, and the lower level then holds its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Ordering policy select |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_fence_i | input | 1 | Request is a fence |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Store data |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_ready_i | input | 1 | Processor takes load data |
| rsp_rdata_o | output | DW | Load data |
| mem_req_valid_o | output | 1 | Lower-level request valid |
| mem_req_ready_i | input | 1 | Lower level accepts request |
| mem_req_write_o | output | 1 | 1 = store retire, 0 = load |
| mem_req_addr_o | output | AW | Lower-level address |
| mem_req_wdata_o | output | DW | Lower-level store data |
| mem_rsp_valid_i | input | 1 | Load data from lower level |
| mem_rsp_rdata_i | input | DW | Load data value |

## Verification
The load that waits for issue and the store that waits to retire can both want the single lower port in the same cycle. The bench provokes this by holding mem_req_ready_i low until stores are buffered and a load has been accepted, then raising it. The first lower-level handshake must be the load, and it must return the value the lower level held before those stores. The stores that follow are compared, one by one, with the order the mode predicts, including a case where a reused low slot makes partial-store-order retire a younger store first.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [1:0] {
    ORD_SEQ  = 2'd0,
    ORD_TSO  = 2'd1,
    ORD_PSO  = 2'd2,
    ORD_SEQ2 = 2'd3
  } ord_mode_e;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_ISSUE,
    LD_WAIT,
    LD_HOLD
  } ld_state_e;

  // write->read pair may be relaxed
  function automatic logic load_may_pass(input logic [1:0] m);
    return (m == ORD_TSO) || (m == ORD_PSO);
  endfunction

  // write->write pair may be relaxed (different addresses only)
  function automatic logic store_may_pass(input logic [1:0] m);
    return (m == ORD_PSO);
  endfunction
endpackage

// File: rtl/sob_slots.sv
module sob_slots #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic [DW-1:0] alloc_data_i,
  input  logic          relax_ww_i,
  input  logic          drain_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          cand_valid_o,
  output logic [AW-1:0] cand_addr_o,
  output logic [DW-1:0] cand_data_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    addr_q  [DEPTH];
  logic [DW-1:0]    data_q  [DEPTH];
  logic [DEPTH-1:0] older_q [DEPTH]; // older_q[j][i]: slot j is older than slot i
  logic [DEPTH-1:0] eligible;
  logic [IW-1:0]    pick_idx;
  logic [IW-1:0]    free_idx;

  function automatic logic [IW-1:0] lowest_set(input logic [DEPTH-1:0] v);
    lowest_set = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (v[k]) lowest_set = IW'(k);
    end
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    logic [DEPTH-1:0] blockers;
    always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
        blockers[j] = vld_q[j] && older_q[j][i] &&
                      (!relax_ww_i || (addr_q[j] == addr_q[i]));
      end
    end
    assign eligible[i] = vld_q[i] && (blockers == '0);
  end

  assign pick_idx     = lowest_set(eligible);
  assign free_idx     = lowest_set(~vld_q);
  assign full_o       = &vld_q;
  assign empty_o      = ~|vld_q;
  assign cand_valid_o = |eligible;
  assign cand_addr_o  = addr_q[pick_idx];
  assign cand_data_o  = data_q[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      if (drain_i) vld_q[pick_idx] <= 1'b0;
      if (alloc_i) begin
        vld_q[free_idx] <= 1'b1;
        for (int j = 0; j < DEPTH; j++) older_q[j][free_idx] <= vld_q[j];
        older_q[free_idx] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i) begin
      addr_q[free_idx] <= alloc_addr_i;
      data_q[free_idx] <= alloc_data_i;
    end
  end

  // Observation wires for the checks below
  logic pick_has_older;
  logic pick_has_older_same;
  always_comb begin
    pick_has_older      = 1'b0;
    pick_has_older_same = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (vld_q[j] && older_q[j][pick_idx]) begin
        pick_has_older = 1'b1;
        if (addr_q[j] == addr_q[pick_idx]) pick_has_older_same = 1'b1;
      end
    end
  end

  assert_inorder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_i && !relax_ww_i) |-> !pick_has_older);
  assert_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> !pick_has_older_same);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !full_o);
  assert_no_empty_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> !empty_o);
endmodule

// File: rtl/sob_load_ctl.sv
module sob_load_ctl
  import sob_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          gnt_i,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  input  logic          rsp_ready_i,
  output logic          busy_o,
  output logic          issue_o,
  output logic [AW-1:0] addr_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  ld_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        LD_IDLE:  if (start_i) begin state_q <= LD_ISSUE; addr_q <= addr_i; end
        LD_ISSUE: if (gnt_i) state_q <= LD_WAIT;
        LD_WAIT:  if (mem_rsp_valid_i) begin state_q <= LD_HOLD; data_q <= mem_rsp_data_i; end
        LD_HOLD:  if (rsp_ready_i) state_q <= LD_IDLE;
        default:  state_q <= LD_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != LD_IDLE);
  assign issue_o     = (state_q == LD_ISSUE);
  assign addr_o      = addr_q;
  assign rsp_valid_o = (state_q == LD_HOLD);
  assign rsp_data_o  = data_q;

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
  assert_single_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == LD_IDLE));
endmodule

// File: rtl/store_order_buf.sv
module store_order_buf
  import sob_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_fence_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_rdata_i
);
  logic          relax_wr, relax_ww;
  logic          buf_full, buf_empty;
  logic          cand_valid;
  logic [AW-1:0] cand_addr;
  logic [DW-1:0] cand_data;
  logic          ld_busy, ld_issue;
  logic [AW-1:0] ld_addr;
  logic          accept, alloc, ld_start, fence_take;
  logic          drain, ld_gnt;

  assign relax_wr = load_may_pass(mode_i);
  assign relax_ww = store_may_pass(mode_i);

  // Admission: one open load blocks everything; fence needs a quiet block
  always_comb begin
    if (ld_busy)          req_ready_o = 1'b0;
    else if (req_fence_i) req_ready_o = buf_empty;
    else if (req_write_i) req_ready_o = !buf_full;
    else                  req_ready_o = relax_wr || buf_empty;
  end

  assign accept     = req_valid_i && req_ready_o;
  assign fence_take = accept && req_fence_i;
  assign alloc      = accept && req_write_i && !req_fence_i;
  assign ld_start   = accept && !req_write_i && !req_fence_i;

  // Lower port: a waiting load goes ahead of any buffered store
  assign mem_req_valid_o = ld_issue || cand_valid;
  assign mem_req_write_o = !ld_issue;
  assign mem_req_addr_o  = ld_issue ? ld_addr : cand_addr;
  assign mem_req_wdata_o = ld_issue ? '0 : cand_data;
  assign drain           = cand_valid && !ld_issue && mem_req_ready_i;
  assign ld_gnt          = ld_issue && mem_req_ready_i;

  sob_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_i      (alloc),
    .alloc_addr_i (req_addr_i),
    .alloc_data_i (req_wdata_i),
    .relax_ww_i   (relax_ww),
    .drain_i      (drain),
    .full_o       (buf_full),
    .empty_o      (buf_empty),
    .cand_valid_o (cand_valid),
    .cand_addr_o  (cand_addr),
    .cand_data_o  (cand_data)
  );

  sob_load_ctl #(.AW(AW), .DW(DW)) u_load (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (ld_start),
    .addr_i          (req_addr_i),
    .gnt_i           (ld_gnt),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_rdata_i),
    .rsp_ready_i     (rsp_ready_i),
    .busy_o          (ld_busy),
    .issue_o         (ld_issue),
    .addr_o          (ld_addr),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_data_o      (rsp_rdata_o)
  );

  assert_seq_load_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_gnt && !relax_wr) |-> buf_empty);
  assert_load_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_issue |-> (mem_req_valid_o && !mem_req_write_o));
  assert_quiet_while_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy |-> !(req_valid_i && req_ready_o));
  assert_fence_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fence_take |-> (buf_empty && !ld_busy));
  assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && req_write_i && !req_fence_i) |-> !req_ready_o);
endmodule

// File: tb/tb_store_order_buf.sv
`timescale 1ns/1ps
module tb_store_order_buf;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic req_valid_i = 0, req_write_i = 0, req_fence_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_ready_i = 1'b1;
  logic [DW-1:0] rsp_rdata_o;
  logic mem_req_valid_o, mem_req_ready_i = 1'b1, mem_req_write_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic mem_rsp_valid_i = 1'b0;
  logic [DW-1:0] mem_rsp_rdata_i = '0;

  always #2.5 clk = ~clk;

  store_order_buf #(.DEPTH(4), .AW(AW), .DW(DW)) dut (.*);

  int n_checks = 0, n_err = 0;
  bit done = 0;
  logic [AW+DW-1:0] exp_st[$];
  logic [DW-1:0]    exp_ld[$];
  bit               kind_log[$]; // 1 = store handshake, 0 = load handshake
  logic [DW-1:0]    mem [16];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Lower-level model and scoreboard monitor
  initial begin
    bit rsp_next;
    logic [DW-1:0] rsp_val;
    rsp_next = 0; rsp_val = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = rsp_next;
      mem_rsp_rdata_i = rsp_val;
      rsp_next = 0;
      #1.5;
      if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
        kind_log.push_back(mem_req_write_o);
        if (mem_req_write_o) begin
          mem[mem_req_addr_o[3:0]] = mem_req_wdata_o;
          if (exp_st.size() == 0)
            chk(0, "R4/R5 unexpected store", {mem_req_addr_o, mem_req_wdata_o}, 0);
          else begin
            logic [AW+DW-1:0] e;
            e = exp_st.pop_front();
            chk(e == {mem_req_addr_o, mem_req_wdata_o}, "R4/R5/R11 store order",
                {mem_req_addr_o, mem_req_wdata_o}, e);
          end
        end else begin
          rsp_next = 1;
          rsp_val  = mem[mem_req_addr_o[3:0]];
        end
      end
      if (rst_n && rsp_valid_o && rsp_ready_i) begin
        if (exp_ld.size() == 0) chk(0, "R1 unexpected response", rsp_rdata_o, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_ld.pop_front();
          chk(rsp_rdata_o == e, "R1 load data", rsp_rdata_o, e);
        end
      end
    end
  end

  task automatic do_req(input bit wr, input bit fence, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit push);
    @(negedge clk);
    req_valid_i = 1; req_write_i = wr; req_fence_i = fence;
    req_addr_i = a; req_wdata_i = d;
    if (push && wr && !fence) exp_st.push_back({a, d});
    for (int k = 0; k < 500; k++) begin
      #1;
      if (req_ready_o) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 0; req_fence_i = 0;
  endtask

  task automatic try_blocked(input bit wr, input bit fence, input string req);
    @(negedge clk);
    req_valid_i = 1; req_write_i = wr; req_fence_i = fence;
    #1;
    chk(!req_ready_o, req, req_ready_o, 0);
    req_valid_i = 0; req_fence_i = 0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (exp_st.size() == 0 && exp_ld.size() == 0 && !rsp_valid_o && !mem_req_valid_o) return;
    end
    chk(0, "R11 drain timeout", exp_st.size(), 0);
  endtask

  task automatic pulse_mem();
    @(negedge clk); mem_req_ready_i = 1;
    @(negedge clk); mem_req_ready_i = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready_o == 1, "R10 ready after reset", req_ready_o, 1);
    chk(mem_req_valid_o == 0, "R10 no lower request", mem_req_valid_o, 0);
    chk(rsp_valid_o == 0, "R10 no response", rsp_valid_o, 0);

    // Sequential mode: load waits for empty buffer
    mode_i = 2'd0; mem_req_ready_i = 0;
    do_req(1, 0, 16'd1, 32'h11, 1);
    do_req(1, 0, 16'd2, 32'h22, 1);
    for (int k = 0; k < 3; k++) try_blocked(0, 0, "R2 seq load held");
    mem_req_ready_i = 1;
    exp_ld.push_back(32'h11);
    do_req(0, 0, 16'd1, '0, 0);
    wait_drain();

    // Total-store-order: load overtakes, stores keep order, no forwarding
    mode_i = 2'd1; mem_req_ready_i = 0;
    do_req(1, 0, 16'd1, 32'h33, 1);
    do_req(1, 0, 16'd3, 32'h44, 1);
    exp_ld.push_back(32'h11);   // old lower-level value, R1
    do_req(0, 0, 16'd1, '0, 0); // accepted with stores pending, R3
    #1;
    chk(mem_req_valid_o && !mem_req_write_o, "R3 load owns port", {mem_req_valid_o, mem_req_write_o}, 2'b10);
    try_blocked(1, 0, "R7 store held during load");
    kind_log.delete();
    @(negedge clk); mem_req_ready_i = 1;
    wait_drain();
    chk(kind_log.size() > 0 && kind_log[0] == 0, "R3 load handshake first",
        kind_log.size() > 0 ? kind_log[0] : 1'b1, 0);
    exp_ld.push_back(32'h33);   // store reached lower level, R11
    do_req(0, 0, 16'd1, '0, 0);
    wait_drain();

    // Response hold
    rsp_ready_i = 0;
    exp_ld.push_back(32'h44);
    do_req(0, 0, 16'd3, '0, 0);
    for (int k = 0; k < 20 && !rsp_valid_o; k++) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(rsp_valid_o && rsp_rdata_o == 32'h44, "R9 response held", rsp_rdata_o, 32'h44);
    end
    rsp_ready_i = 1;
    wait_drain();

    // Total-store-order with slot reuse: strict arrival order
    mem_req_ready_i = 0;
    do_req(1, 0, 16'd4, 32'hA0, 1);
    do_req(1, 0, 16'd5, 32'hA1, 1);
    do_req(1, 0, 16'd6, 32'hA2, 1);
    do_req(1, 0, 16'd7, 32'hA3, 1);
    try_blocked(1, 0, "R6 full stall");
    pulse_mem();
    do_req(1, 0, 16'd8, 32'hB0, 1);
    @(negedge clk); mem_req_ready_i = 1;
    wait_drain();

    // Partial-store-order: reused low slot retires first (R5)
    mode_i = 2'd2; mem_req_ready_i = 0;
    exp_st.push_back({16'd4, 32'hC0});
    exp_st.push_back({16'd8, 32'hD0});
    exp_st.push_back({16'd5, 32'hC1});
    exp_st.push_back({16'd6, 32'hC2});
    exp_st.push_back({16'd7, 32'hC3});
    do_req(1, 0, 16'd4, 32'hC0, 0);
    do_req(1, 0, 16'd5, 32'hC1, 0);
    do_req(1, 0, 16'd6, 32'hC2, 0);
    do_req(1, 0, 16'd7, 32'hC3, 0);
    try_blocked(1, 0, "R6 full stall pso");
    pulse_mem();
    do_req(1, 0, 16'd8, 32'hD0, 0);
    @(negedge clk); mem_req_ready_i = 1;
    wait_drain();

    // Partial-store-order: same address keeps order (R5)
    mem_req_ready_i = 0;
    exp_st.push_back({16'd4, 32'hE0});
    exp_st.push_back({16'd5, 32'hE1});
    exp_st.push_back({16'd5, 32'hE4});
    exp_st.push_back({16'd6, 32'hE2});
    exp_st.push_back({16'd7, 32'hE3});
    do_req(1, 0, 16'd4, 32'hE0, 0);
    do_req(1, 0, 16'd5, 32'hE1, 0);
    do_req(1, 0, 16'd6, 32'hE2, 0);
    do_req(1, 0, 16'd7, 32'hE3, 0);
    pulse_mem();
    do_req(1, 0, 16'd5, 32'hE4, 0);
    @(negedge clk); mem_req_ready_i = 1;
    wait_drain();
    exp_ld.push_back(32'hE4);
    do_req(0, 0, 16'd5, '0, 0);
    wait_drain();

    // Fence waits for a quiet block (R8)
    mode_i = 2'd1; mem_req_ready_i = 0;
    do_req(1, 0, 16'd9, 32'hF0, 1);
    for (int k = 0; k < 3; k++) try_blocked(1, 1, "R8 fence held");
    mem_req_ready_i = 1;
    kind_log.delete();
    do_req(0, 1, 16'd0, '0, 0);
    chk(exp_st.size() == 0, "R8 buffer empty at fence", exp_st.size(), 0);
    repeat (3) @(negedge clk);
    chk(kind_log.size() == 1, "R8 fence issues nothing", kind_log.size(), 1);

    // Mode 3 behaves as sequential (R2)
    mode_i = 2'd3; mem_req_ready_i = 0;
    do_req(1, 0, 16'd10, 32'h77, 1);
    try_blocked(0, 0, "R2 mode3 load held");
    mem_req_ready_i = 1;
    wait_drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog R11 actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule